// File: doc/BRIEF.md
# Converter Serial Frame Engine

This block is the digital front end that sits between a host serial port and a 16-channel, 12-bit sampling converter. The host frames each transfer with an active-low chip select and a serial clock that idles low. In every 16-clock frame the block returns a 16-bit word and takes in a 16-bit command word at the same time. The word it returns is a 4-bit header followed by the 12-bit result, most significant bit first. The header is either the channel being converted or a snapshot of four general-purpose input pins.

During the frame the block also issues strobes to the analog side at fixed positions: sample, mux switch, acquisition start and conversion done. It refreshes the general-purpose outputs and manages the power-down state. The conversion result and the channel number arrive on parallel inputs. When a frame completes, the received command word is handed to an external sequencer with a one-cycle pulse.

All serial pins are brought into the system clock domain through two-stage synchronisers. Edge detection is done on the synchronised copies. Every frame position is counted in SCLK edges, not in system clocks.

Top module: `adc_frame_engine`

## Requirements
- R1: A chip-select falling edge starts a frame: SDO is enabled and carries bit 15 of the outgoing word, and `sample_stb` pulses once for one clock.
- R2: Outgoing bits 14 down to 0 appear on SCLK falling edges 1 to 15. The word is {header[3:0], result[11:0]} with result MSB at bit 11, and header and result are captured at the chip-select falling edge.
- R3: On the 16th SCLK falling edge SDO is released (`sdo_oe` low) and `conv_done` pulses once.
- R4: SDI is captured on each SCLK rising edge, first bit into command bit 15. On the chip-select rising edge after a full frame, `frame_done` pulses once and `frame_cmd` holds the 16-bit command.
- R5: `mux_stb` pulses once per frame, after SCLK falling edge 2. `acq_stb` pulses once per frame, after SCLK rising edge 14.
- R6: If bit 4 of the last completed command is 1, the header carries `gpio_in[3:0]` (pin 3 in bit 15). Otherwise it carries `conv_chan`.
- R7: At the chip-select falling edge, each `gpio_out` pin with `gpio_dir` = 1 takes bit [3:0] of the last completed command. Pins with `gpio_dir` = 0 keep their value.
- R8: Command bit 5 = 1 makes `powered_down` rise at the 16th SCLK falling edge of the following frame, and not before.
- R9: `pd_n` low drives `powered_down` high without waiting for a clock. The state stays set after `pd_n` returns high, until a wake-up occurs.
- R10: A wake-up happens at a chip-select falling edge only when the last completed command has bit 5 = 0 and `pd_n` is high. That frame returns the word 0x0000.
- R11: After reset, `sdo_oe`, `gpio_out`, `frame_cmd`, `frame_done` and `powered_down` are 0, and the first frame returns the word 0x0000.
- R12: If chip select rises before 16 SCLK falling edges, SDO is released, `frame_done` does not pulse, and the partial command is discarded.
- R13: `sdo_oe` is low whenever chip select has been high for three clocks. SCLK edges while chip select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial command data from host |
| conv_result | input | 12 | Conversion result from the converter |
| conv_chan | input | 4 | Channel number of the current sample |
| gpio_in | input | 4 | General-purpose pin input levels |
| gpio_dir | input | 4 | Per-pin direction, 1 = output |
| pd_n | input | 1 | Active-low asynchronous power-down request |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | SDO output enable, 0 = high impedance |
| sample_stb | output | 1 | Sample pulse at frame start |
| mux_stb | output | 1 | Mux switch pulse |
| acq_stb | output | 1 | Acquisition start pulse |
| conv_done | output | 1 | Conversion complete pulse |
| powered_down | output | 1 | Analog power-down state |
| gpio_out | output | 4 | General-purpose output levels |
| frame_done | output | 1 | Completed frame pulse for the sequencer |
| frame_cmd | output | 16 | Last completed command word |

## Verification
Each pin edge passes through two synchroniser flops and one edge-detect stage. Every registered result (SDO bit, enable, strobe, GPIO, power state) therefore settles by the third system clock after the pin changes. The one exception is the power-down pin, which acts within the same cycle.

The bench drives pin edges eight clocks apart. It samples SDO just before the next SCLK rise, and checks every other result at least four clocks after the edge that caused it. Strobe positions are recorded against the bench's own count of SCLK edges issued, so each strobe is tied to the edge that caused it, not to a clock count.

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int RES_W = 12,
  parameter int HDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic [RES_W-1:0]       conv_result,
  input  logic [HDR_W-1:0]       conv_chan,
  input  logic [HDR_W-1:0]       gpio_in,
  input  logic [HDR_W-1:0]       gpio_dir,
  input  logic                   pd_n,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic                   sample_stb,
  output logic                   mux_stb,
  output logic                   acq_stb,
  output logic                   conv_done,
  output logic                   powered_down,
  output logic [HDR_W-1:0]       gpio_out,
  output logic                   frame_done,
  output logic [RES_W+HDR_W-1:0] frame_cmd
);
  localparam int FW     = RES_W + HDR_W;
  localparam int CNT_W  = $clog2(FW + 1);
  localparam int BIT_GR = HDR_W;
  localparam int BIT_PD = HDR_W + 1;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(FW);
  localparam logic [CNT_W-1:0] MUX_AT = CNT_W'(1);
  localparam logic [CNT_W-1:0] ACQ_AT = CNT_W'(FW - 3);

  logic [2:0] cs_q, sck_q;
  logic [1:0] sdi_q, pdn_q;
  logic in_frame, pd_r, inv_r;
  logic [CNT_W-1:0] fcnt, rcnt;
  logic [FW-1:0] shreg, rx;
  logic [HDR_W-1:0] hdr;
  logic [FW-1:0] word;
  logic cs_fall, cs_rise, sck_rise, sck_fall, wake;

  assign cs_fall  = cs_q[2] & ~cs_q[1];
  assign cs_rise  = ~cs_q[2] & cs_q[1];
  assign sck_rise = in_frame & ~sck_q[2] & sck_q[1];
  assign sck_fall = in_frame & sck_q[2] & ~sck_q[1];
  assign hdr  = frame_cmd[BIT_GR] ? gpio_in : conv_chan;
  assign word = inv_r ? '0 : {hdr, conv_result};
  assign wake = pd_r & ~frame_cmd[BIT_PD] & pdn_q[1];
  assign powered_down = pd_r | ~pd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      sdi_q <= '0;
      pdn_q <= '1;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sclk};
      sdi_q <= {sdi_q[0], sdi};
      pdn_q <= {pdn_q[0], pd_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      fcnt       <= '0;
      rcnt       <= '0;
      shreg      <= '0;
      rx         <= '0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
      sample_stb <= 1'b0;
      mux_stb    <= 1'b0;
      acq_stb    <= 1'b0;
      conv_done  <= 1'b0;
      frame_done <= 1'b0;
      frame_cmd  <= '0;
      gpio_out   <= '0;
      pd_r       <= 1'b0;
      inv_r      <= 1'b1;
    end else begin
      sample_stb <= 1'b0;
      mux_stb    <= 1'b0;
      acq_stb    <= 1'b0;
      conv_done  <= 1'b0;
      frame_done <= 1'b0;
      if (cs_fall) begin
        in_frame   <= 1'b1;
        fcnt       <= '0;
        rcnt       <= '0;
        sample_stb <= 1'b1;
        shreg      <= word;
        sdo        <= word[FW-1];
        sdo_oe     <= 1'b1;
        gpio_out   <= (gpio_out & ~gpio_dir) | (frame_cmd[HDR_W-1:0] & gpio_dir);
        if (wake) pd_r <= 1'b0;
        inv_r      <= pd_r & ~wake;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
        sdo_oe   <= 1'b0;
        sdo      <= 1'b0;
        if (fcnt == FULL) begin
          frame_done <= 1'b1;
          frame_cmd  <= rx;
        end
      end else begin
        if (sck_rise && rcnt != FULL) begin
          rx   <= {rx[FW-2:0], sdi_q[1]};
          rcnt <= rcnt + 1'b1;
          if (rcnt == ACQ_AT) acq_stb <= 1'b1;
        end
        if (sck_fall && fcnt != FULL) begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == MUX_AT) mux_stb <= 1'b1;
          if (fcnt == LAST) begin
            sdo_oe    <= 1'b0;
            sdo       <= 1'b0;
            conv_done <= 1'b1;
            if (frame_cmd[BIT_PD]) begin
              pd_r  <= 1'b1;
              inv_r <= 1'b1;
            end
          end else begin
            sdo   <= shreg[FW-2];
            shreg <= shreg << 1;
          end
        end
      end
      if (!pdn_q[1]) begin
        pd_r  <= 1'b1;
        inv_r <= 1'b1;
      end
    end
  end
endmodule

module adc_frame_engine_chk #(
  parameter int HDR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             pd_n,
  input logic             sdo_oe,
  input logic             sample_stb,
  input logic             mux_stb,
  input logic             acq_stb,
  input logic             conv_done,
  input logic             powered_down,
  input logic [HDR_W-1:0] gpio_out,
  input logic             frame_done
);
  // R3
  release_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !sdo_oe);
  // R13
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdo_oe);
  // R5
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, mux_stb, acq_stb, conv_done, frame_done}));
  // R4
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !sdo_oe);
  // R10
  wake_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered_down) && pd_n && $past(pd_n) |-> sample_stb);
  // R9
  pin_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> powered_down);
  // R7
  gpio_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_out) |-> sample_stb);
endmodule

bind adc_frame_engine adc_frame_engine_chk #(.HDR_W(HDR_W)) u_chk (.*);

// File: tb/adc_frame_engine_tb.sv
module adc_frame_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, pd_n = 1'b1;
  logic [11:0] conv_result = '0;
  logic [3:0] conv_chan = '0, gpio_in = '0, gpio_dir = '0;
  logic sdo, sdo_oe, sample_stb, mux_stb, acq_stb, conv_done, powered_down, frame_done;
  logic [3:0] gpio_out;
  logic [15:0] frame_cmd;

  adc_frame_engine u_dut (.*);

  always #5 clk = ~clk;

  int total = 0, failed = 0;
  int fidx = 0, ridx = 0;
  int smp_n, mux_n, acq_n, cd_n, fd_n, mux_at, acq_at, cd_at;
  bit skip = 1'b0, finished = 1'b0;
  logic [15:0] expq[$];
  logic [15:0] m_cmd = '0;
  logic [3:0] m_gpo = '0;
  bit m_inv = 1'b1, m_pd = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (sample_stb) smp_n++;
    if (mux_stb) begin mux_n++; mux_at = fidx; end
    if (acq_stb) begin acq_n++; acq_at = ridx; end
    if (conv_done) begin cd_n++; cd_at = fidx; end
    if (frame_done) fd_n++;
  end

  initial begin : monitor
    logic [15:0] got, exp;
    forever begin
      @(negedge cs_n);
      if (!skip) begin
        for (int i = 0; i < 16; i++) begin
          @(posedge sclk);
          got[15-i] = sdo;
          if (!sdo_oe) chk(1'b0, "R1 sdo enabled during frame", 32'(sdo_oe), 32'd1);
        end
        exp = expq.pop_front();
        chk(got == exp, "R2 serial word", 32'(got), 32'(exp));
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    smp_n = 0; mux_n = 0; acq_n = 0; cd_n = 0; fd_n = 0;
    mux_at = -1; acq_at = -1; cd_at = -1; fidx = 0; ridx = 0;
  endtask

  task automatic do_frame(input logic [15:0] cmd, input int nclk);
    logic [3:0] hdr;
    bit full;
    full = (nclk == 16);
    hdr = m_cmd[4] ? gpio_in : conv_chan;
    if (full) expq.push_back(m_inv ? 16'h0000 : {hdr, conv_result});
    skip = !full;
    if (m_pd && !m_cmd[5] && pd_n) m_pd = 1'b0;
    m_inv = m_pd;
    m_gpo = (m_gpo & ~gpio_dir) | (m_cmd[3:0] & gpio_dir);
    clear_counts();
    @(negedge clk) cs_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nclk; i++) begin
      sdi = cmd[15-i];
      wclk(4);
      sclk = 1'b1; ridx++;
      wclk(8);
      if (i == 15) chk(powered_down == m_pd, "R8 no early power-down", 32'(powered_down), 32'(m_pd));
      sclk = 1'b0; fidx++;
      wclk(4);
    end
    wclk(4);
    if (full) begin
      if (m_cmd[5]) begin m_pd = 1'b1; m_inv = 1'b1; end
      chk(sdo_oe == 1'b0, "R3 sdo released after edge 16", 32'(sdo_oe), 32'd0);
    end
    cs_n = 1'b1;
    wclk(10);
    chk(sdo_oe == 1'b0, "R13 sdo off with cs high", 32'(sdo_oe), 32'd0);
    chk(smp_n == 1, "R1 one sample strobe", 32'(smp_n), 32'd1);
    chk(gpio_out == m_gpo, "R7 gpio outputs", 32'(gpio_out), 32'(m_gpo));
    chk(powered_down == m_pd, "R8 power state", 32'(powered_down), 32'(m_pd));
    if (full) begin
      m_cmd = cmd;
      chk(mux_n == 1 && mux_at == 2, "R5 mux strobe at fall 2", 32'(mux_at), 32'd2);
      chk(acq_n == 1 && acq_at == 14, "R5 acq strobe at rise 14", 32'(acq_at), 32'd14);
      chk(cd_n == 1 && cd_at == 16, "R3 conv_done at fall 16", 32'(cd_at), 32'd16);
      chk(fd_n == 1, "R4 frame_done pulse", 32'(fd_n), 32'd1);
      chk(frame_cmd == cmd, "R4 command word", 32'(frame_cmd), 32'(cmd));
    end else begin
      chk(fd_n == 0, "R12 no frame_done on abort", 32'(fd_n), 32'd0);
      chk(frame_cmd == m_cmd, "R12 command discarded", 32'(frame_cmd), 32'(m_cmd));
    end
    skip = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin : driver
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    // R11 reset state
    chk(sdo_oe == 1'b0 && frame_done == 1'b0, "R11 reset outputs", {30'd0, sdo_oe, frame_done}, 32'd0);
    chk(gpio_out == 4'h0 && frame_cmd == 16'h0, "R11 reset registers", {12'd0, gpio_out, frame_cmd}, 32'd0);
    chk(powered_down == 1'b0, "R11 powered up after reset", 32'(powered_down), 32'd0);
    // R11 first frame is zero
    conv_result = 12'hABC; conv_chan = 4'h5; gpio_dir = 4'b0101;
    do_frame(16'h0000, 16);
    // R6 channel header, command asks for gpio read and outputs
    conv_result = 12'h123; conv_chan = 4'h3;
    do_frame(16'h001F, 16);
    // R6 gpio header, R7 masked outputs
    conv_result = 12'h456; gpio_in = 4'hA;
    do_frame(16'h0000, 16);
    conv_result = 12'hFFF; conv_chan = 4'hF;
    do_frame(16'h0000, 16);
    // R13 stray SCLK with cs high
    clear_counts();
    repeat (4) begin sclk = 1'b1; wclk(6); sclk = 1'b0; wclk(6); end
    chk(sdo_oe == 1'b0 && (mux_n + acq_n + cd_n + fd_n) == 0, "R13 idle sclk ignored",
        32'(mux_n + acq_n + cd_n + fd_n), 32'd0);
    // R12 aborted frame carrying gpio read and power-down bits
    do_frame(16'h003F, 5);
    conv_result = 12'h001; conv_chan = 4'h0;
    do_frame(16'h0020, 16);
    // R8 takes effect in this frame
    conv_result = 12'h800; conv_chan = 4'h9;
    do_frame(16'h0000, 16);
    // R10 wake frame returns zero
    do_frame(16'h0000, 16);
    conv_result = 12'h777; conv_chan = 4'h2;
    do_frame(16'h0000, 16);
    // R9 asynchronous pin power-down
    @(negedge clk) pd_n = 1'b0;
    #1 chk(powered_down == 1'b1, "R9 immediate power-down", 32'(powered_down), 32'd1);
    wclk(5);
    pd_n = 1'b1;
    wclk(5);
    chk(powered_down == 1'b1, "R9 power-down held", 32'(powered_down), 32'd1);
    m_pd = 1'b1; m_inv = 1'b1;
    // R10 wake again, zero word then valid
    conv_result = 12'h3C5; conv_chan = 4'h7;
    do_frame(16'h0000, 16);
    do_frame(16'h0000, 16);
    wclk(20);
    chk(expq.size() == 0, "R2 all words observed", 32'(expq.size()), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule